// File: doc/BRIEF.md
# Non-Contiguous I/O Window Translator

This block claims CPU-side accesses that land in an 8 MB memory window based at CPU address 0x8000_0000 and reissues them as I/O-space accesses. Two address translations are available. The contiguous translation keeps the low 16 bits of the window offset, which gives a 64 KB I/O space. The sparse translation spreads I/O space across the window. It keeps the low 5 offset bits and moves offset bits 12 and up down by 7 places, so every 4 KB page of the window reaches only 32 I/O bytes.

A single mode bit selects the translation. Software sets that bit by writing a byte to a configuration port at I/O address 0x850. Each claimed request with a legal size of 1, 2 or 4 bytes is held on the I/O side until the I/O side signals ready. Data travels in both directions unchanged, in little-endian lane order. A request with any other size ends at once with an error flag and does not reach the I/O side.

Top module: `io_window_xlat`

## Requirements
- R1: `cpu_hit` is high exactly when `cpu_req` is high and `cpu_addr` lies in [0x8000_0000, 0x8080_0000). A request outside that range produces neither `io_req` nor `cpu_ready`.
- R2: In contiguous mode (mode bit 0), `io_addr` equals bits 15:0 of the offset `cpu_addr - 0x8000_0000`.
- R3: In sparse mode (mode bit 1), `io_addr` equals `(offset & 0x1F) | ((offset & 0x7FFF000) >> 7)`.
- R4: Offset bits that the active mode drops do not affect `io_addr`. These are bits 5 to 11 in sparse mode and bits 16 to 22 in contiguous mode.
- R5: The mode bit resets to 0. A `cfg_wr` pulse with `cfg_port` equal to 0x850 loads the bit from `cfg_wdata[0]`. Writes to any other port, and bits 7:1 of the data, have no effect.
- R6: `cpu_size` holds the byte count. A claimed request whose size is not 1, 2 or 4 raises `cpu_ready` and `cpu_err` together for one cycle, starting the cycle after it is accepted, and never raises `io_req`.
- R7: For a legal request, `io_size` copies the size, and `io_be` is 4'b0001, 4'b0011 or 4'b1111 for sizes 1, 2 and 4. `io_wdata` equals `cpu_wdata` and `io_we` equals `cpu_we`. `cpu_rdata` equals `io_rdata` while `cpu_ready` is high and `cpu_err` is low.
- R8: `io_req` rises in the cycle after acceptance. While `io_ready` is low, `io_req`, `io_addr`, `io_size`, `io_we` and `io_wdata` hold steady. `cpu_ready` is high in the same cycle as `io_ready`, and `io_req` falls after that cycle.
- R9: A request is translated with the mode bit in force in the cycle it is accepted. A mode write in that same cycle, or while the request is still outstanding, applies only to later requests.
- R10: A start address that is not aligned to the access size is forwarded translated as-is, with no alignment applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU request, held until `cpu_ready` |
| cpu_we | input | 1 | CPU write (1) or read (0) |
| cpu_addr | input | 32 | CPU byte address |
| cpu_size | input | 3 | Access size in bytes |
| cpu_wdata | input | 32 | CPU write data, little-endian lanes |
| cpu_hit | output | 1 | Request falls in the window |
| cpu_ready | output | 1 | CPU access completes this cycle |
| cpu_err | output | 1 | Completion carries an illegal-size error |
| cpu_rdata | output | 32 | Read data back to the CPU |
| cfg_wr | input | 1 | Configuration port write strobe |
| cfg_port | input | 16 | Configuration port address |
| cfg_wdata | input | 8 | Configuration write byte |
| io_req | output | 1 | I/O request pending |
| io_we | output | 1 | I/O write (1) or read (0) |
| io_addr | output | 16 | Translated I/O address |
| io_size | output | 3 | I/O access size in bytes |
| io_be | output | 4 | I/O byte-lane enables |
| io_wdata | output | 32 | I/O write data |
| io_ready | input | 1 | I/O side completes the request |
| io_rdata | input | 32 | I/O read data |

## Verification
A write to the mode port can land in the same cycle that a window request is accepted, or while an earlier request is still waiting for `io_ready`. The bench provokes both cases directly. It raises `cfg_wr` on the same falling edge that presents `cpu_req`. It also writes the port during an I/O stall of several cycles. The random phase then mixes mode writes with accesses. In each case the bench predicts the translated address from the mode that held before the write, and it checks that the next request uses the new mode.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_BUSY = 2'd1,
      XS_FAIL = 2'd2
   } xlat_state_t;

   function automatic logic size_is_legal(input logic [2:0] nbytes);
      return (nbytes == 3'd1) || (nbytes == 3'd2) || (nbytes == 3'd4);
   endfunction

   function automatic logic [3:0] lanes_for_size(input logic [2:0] nbytes);
      case (nbytes)
         3'd1:    return 4'b0001;
         3'd2:    return 4'b0011;
         3'd4:    return 4'b1111;
         default: return 4'b0000;
      endcase
   endfunction

endpackage

// File: rtl/xlat_window_map.sv
module xlat_window_map #(
   parameter int          CPU_AW   = 32,
   parameter logic [31:0] WIN_BASE = 32'h8000_0000,
   parameter int          WIN_LOG2 = 23,
   parameter int          IO_AW    = 16,
   parameter int          LOW_KEEP = 5,
   parameter int          PAGE_LOG2 = 12,
   parameter int          CONT_BITS = 16
) (
   input  logic [CPU_AW-1:0] addr,
   input  logic              sparse,
   output logic              in_win,
   output logic [IO_AW-1:0]  io_addr
);
   localparam int SHIFT   = PAGE_LOG2 - LOW_KEEP;
   localparam int HI_TOP  = 26;
   localparam int HI_LAST = HI_TOP - SHIFT;

   logic [WIN_LOG2-1:0] offs;
   logic [IO_AW-1:0]    cont_a;
   logic [IO_AW-1:0]    sparse_a;

   assign in_win = (addr[CPU_AW-1:WIN_LOG2] == WIN_BASE[CPU_AW-1:WIN_LOG2]);
   assign offs   = addr[WIN_LOG2-1:0];

   for (genvar i = 0; i < IO_AW; i++) begin : g_bit
      if (i < CONT_BITS && i < WIN_LOG2) begin : g_cont
         assign cont_a[i] = offs[i];
      end else begin : g_cont_zero
         assign cont_a[i] = 1'b0;
      end

      if (i < LOW_KEEP) begin : g_low
         assign sparse_a[i] = offs[i];
      end else if (i <= HI_LAST && (i + SHIFT) < WIN_LOG2) begin : g_page
         assign sparse_a[i] = offs[i+SHIFT];
      end else begin : g_sparse_zero
         assign sparse_a[i] = 1'b0;
      end
   end

   assign io_addr = sparse ? sparse_a : cont_a;

endmodule

// File: rtl/xlat_mode_reg.sv
module xlat_mode_reg #(
   parameter int                 PORT_AW  = 16,
   parameter logic [PORT_AW-1:0] MODE_PORT = 16'h0850
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [PORT_AW-1:0] port,
   input  logic [7:0]         wdata,
   output logic               sparse
);
   logic hit_port;

   assign hit_port = wr && (port == MODE_PORT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sparse <= 1'b0;
      end else if (hit_port) begin
         sparse <= wdata[0];
      end
   end

endmodule

// File: rtl/xlat_req_stage.sv
module xlat_req_stage
   import xlat_pkg::*;
#(
   parameter int IO_AW = 16,
   parameter int DW    = 32,
   localparam int NB   = DW / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             claim,
   input  logic             we,
   input  logic [2:0]       nbytes,
   input  logic [DW-1:0]    wdata,
   input  logic [IO_AW-1:0] xaddr,
   input  logic             io_ready,
   output logic             io_req,
   output logic             io_we,
   output logic [IO_AW-1:0] io_addr,
   output logic [2:0]       io_size,
   output logic [NB-1:0]    io_be,
   output logic [DW-1:0]    io_wdata,
   output logic             done,
   output logic             fail
);
   xlat_state_t state, state_nx;
   logic        take;

   assign take = (state == XS_IDLE) && claim;

   always_comb begin
      state_nx = state;
      case (state)
         XS_IDLE: if (claim) state_nx = size_is_legal(nbytes) ? XS_BUSY : XS_FAIL;
         XS_BUSY: if (io_ready) state_nx = XS_IDLE;
         XS_FAIL: state_nx = XS_IDLE;
         default: state_nx = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= XS_IDLE;
      end else begin
         state <= state_nx;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         io_we    <= 1'b0;
         io_addr  <= '0;
         io_size  <= '0;
         io_be    <= '0;
         io_wdata <= '0;
      end else if (take && size_is_legal(nbytes)) begin
         io_we    <= we;
         io_addr  <= xaddr;
         io_size  <= nbytes;
         io_be    <= NB'(lanes_for_size(nbytes));
         io_wdata <= wdata;
      end
   end

   assign io_req = (state == XS_BUSY);
   assign done   = ((state == XS_BUSY) && io_ready) || (state == XS_FAIL);
   assign fail   = (state == XS_FAIL);

endmodule

// File: rtl/io_window_xlat.sv
module io_window_xlat #(
   parameter int                 CPU_AW    = 32,
   parameter logic [31:0]        WIN_BASE  = 32'h8000_0000,
   parameter int                 WIN_LOG2  = 23,
   parameter int                 IO_AW     = 16,
   parameter int                 DW        = 32,
   parameter int                 PORT_AW   = 16,
   parameter logic [PORT_AW-1:0] MODE_PORT = 16'h0850,
   localparam int                NB        = DW / 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [CPU_AW-1:0]  cpu_addr,
   input  logic [2:0]         cpu_size,
   input  logic [DW-1:0]      cpu_wdata,
   output logic               cpu_hit,
   output logic               cpu_ready,
   output logic               cpu_err,
   output logic [DW-1:0]      cpu_rdata,
   input  logic               cfg_wr,
   input  logic [PORT_AW-1:0] cfg_port,
   input  logic [7:0]         cfg_wdata,
   output logic               io_req,
   output logic               io_we,
   output logic [IO_AW-1:0]   io_addr,
   output logic [2:0]         io_size,
   output logic [NB-1:0]      io_be,
   output logic [DW-1:0]      io_wdata,
   input  logic               io_ready,
   input  logic [DW-1:0]      io_rdata
);
   if (DW != 32) begin : g_bad_dw
      $error("io_window_xlat: data path must be 32 bits wide");
   end
   if (WIN_LOG2 < 5 || WIN_LOG2 >= CPU_AW) begin : g_bad_win
      $error("io_window_xlat: window size out of range");
   end
   if (IO_AW < 16) begin : g_bad_io
      $error("io_window_xlat: I/O address narrower than 16 bits");
   end
   if (WIN_BASE[WIN_LOG2-1:0] != '0) begin : g_bad_base
      $error("io_window_xlat: window base not aligned to its size");
   end

   logic             in_win;
   logic             map_nc;
   logic [IO_AW-1:0] xaddr;
   logic             done;
   logic             fail;

   xlat_mode_reg #(
      .PORT_AW  (PORT_AW),
      .MODE_PORT(MODE_PORT)
   ) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .port  (cfg_port),
      .wdata (cfg_wdata),
      .sparse(map_nc)
   );

   xlat_window_map #(
      .CPU_AW  (CPU_AW),
      .WIN_BASE(WIN_BASE),
      .WIN_LOG2(WIN_LOG2),
      .IO_AW   (IO_AW)
   ) u_map (
      .addr   (cpu_addr),
      .sparse (map_nc),
      .in_win (in_win),
      .io_addr(xaddr)
   );

   assign cpu_hit = cpu_req && in_win;

   xlat_req_stage #(
      .IO_AW(IO_AW),
      .DW   (DW)
   ) u_req (
      .clk     (clk),
      .rst_n   (rst_n),
      .claim   (cpu_hit),
      .we      (cpu_we),
      .nbytes  (cpu_size),
      .wdata   (cpu_wdata),
      .xaddr   (xaddr),
      .io_ready(io_ready),
      .io_req  (io_req),
      .io_we   (io_we),
      .io_addr (io_addr),
      .io_size (io_size),
      .io_be   (io_be),
      .io_wdata(io_wdata),
      .done    (done),
      .fail    (fail)
   );

   assign cpu_ready = done;
   assign cpu_err   = fail;
   assign cpu_rdata = (done && !fail) ? io_rdata : '0;

endmodule

// File: rtl/io_window_xlat_chk.sv
module io_window_xlat_chk #(
   parameter int IO_AW   = 16,
   parameter int DW      = 32,
   parameter int PORT_AW = 16,
   parameter logic [PORT_AW-1:0] MODE_PORT = 16'h0850
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cpu_req,
   input logic               cpu_hit,
   input logic               cpu_ready,
   input logic               cpu_err,
   input logic               cfg_wr,
   input logic [PORT_AW-1:0] cfg_port,
   input logic               map_nc,
   input logic               io_req,
   input logic               io_we,
   input logic [IO_AW-1:0]   io_addr,
   input logic [2:0]         io_size,
   input logic [DW/8-1:0]    io_be,
   input logic [DW-1:0]      io_wdata,
   input logic               io_ready
);
   AST_MISS_NO_IO: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_hit && !io_req && !cpu_err) |=> !io_req); // R1

   AST_IO_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(io_req) |-> $past(cpu_hit)); // R1

   AST_MODE_ONLY_PORT: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_wr && cfg_port == MODE_PORT) |=> $stable(map_nc)); // R5

   AST_ERR_NO_IO: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_err |-> (cpu_ready && !io_req)); // R6

   AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_err |=> !cpu_err); // R6

   AST_LANES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      io_req |-> ((io_size == 3'd1 && io_be == 4'b0001) ||
                  (io_size == 3'd2 && io_be == 4'b0011) ||
                  (io_size == 3'd4 && io_be == 4'b1111))); // R7

   AST_IO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && !io_ready) |=> (io_req && $stable(io_addr) && $stable(io_size) &&
                                 $stable(io_we) && $stable(io_wdata))); // R8

   AST_READY_WITH_IO: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_ready && !cpu_err) |-> (io_req && io_ready)); // R8

   AST_IO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (io_req && io_ready) |=> !io_req); // R8

endmodule

bind io_window_xlat io_window_xlat_chk #(
   .IO_AW    (IO_AW),
   .DW       (DW),
   .PORT_AW  (PORT_AW),
   .MODE_PORT(MODE_PORT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cpu_req  (cpu_req),
   .cpu_hit  (cpu_hit),
   .cpu_ready(cpu_ready),
   .cpu_err  (cpu_err),
   .cfg_wr   (cfg_wr),
   .cfg_port (cfg_port),
   .map_nc   (map_nc),
   .io_req   (io_req),
   .io_we    (io_we),
   .io_addr  (io_addr),
   .io_size  (io_size),
   .io_be    (io_be),
   .io_wdata (io_wdata),
   .io_ready (io_ready)
);

// File: tb/sim_io_window_xlat.sv
`timescale 1ns/1ps
module sim_io_window_xlat;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [2:0]  cpu_size = '0;
   logic        cpu_hit, cpu_ready, cpu_err;
   logic [31:0] cpu_rdata;
   logic        cfg_wr = 1'b0;
   logic [15:0] cfg_port = '0;
   logic [7:0]  cfg_wdata = '0;
   logic        io_req, io_we;
   logic [15:0] io_addr;
   logic [2:0]  io_size;
   logic [3:0]  io_be;
   logic [31:0] io_wdata;
   logic        io_ready = 1'b0;
   logic [31:0] io_rdata = '0;

   int total = 0;
   int bad = 0;
   bit mode = 1'b0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   io_window_xlat u0 (
      .clk(clk), .rst_n(rst_n),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_size(cpu_size),
      .cpu_wdata(cpu_wdata), .cpu_hit(cpu_hit), .cpu_ready(cpu_ready), .cpu_err(cpu_err),
      .cpu_rdata(cpu_rdata), .cfg_wr(cfg_wr), .cfg_port(cfg_port), .cfg_wdata(cfg_wdata),
      .io_req(io_req), .io_we(io_we), .io_addr(io_addr), .io_size(io_size), .io_be(io_be),
      .io_wdata(io_wdata), .io_ready(io_ready), .io_rdata(io_rdata)
   );

   function automatic bit f_hit(input logic [31:0] a);
      return (a >= 32'h8000_0000) && (a < 32'h8080_0000);
   endfunction

   function automatic logic [15:0] f_xlat(input logic [31:0] a, input bit m);
      logic [31:0] off;
      off = a - 32'h8000_0000;
      if (m) return 16'(((off & 32'h1F) | ((off & 32'h07FF_F000) >> 7)));
      return 16'(off & 32'hFFFF);
   endfunction

   function automatic logic [3:0] f_be(input logic [2:0] s);
      return (s == 3'd1) ? 4'b0001 : (s == 3'd2) ? 4'b0011 : 4'b1111;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [15:0] port, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_port = port; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
      if (port == 16'h0850) mode = d[0];
   endtask

   task automatic access(input logic [31:0] a, input logic [2:0] sz, input bit we,
                         input logic [31:0] wd, input int dly, input int cfg_now,
                         input int cfg_mid, input string tag);
      bit          h, legal;
      logic [15:0] ea;
      logic [31:0] rd;
      h     = f_hit(a);
      legal = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
      ea    = f_xlat(a, mode);
      @(negedge clk);
      cpu_req = 1'b1; cpu_addr = a; cpu_size = sz; cpu_we = we; cpu_wdata = wd;
      if (cfg_now >= 0) begin
         cfg_wr = 1'b1; cfg_port = 16'h0850; cfg_wdata = 8'(cfg_now);
      end
      #1;
      chk(cpu_hit == h, {tag, " R1 hit"}, 32'(cpu_hit), 32'(h));
      @(negedge clk);
      if (cfg_now >= 0) begin
         cfg_wr = 1'b0;
         mode = cfg_now[0];
      end
      if (!h) begin
         chk(!io_req && !cpu_ready, {tag, " R1 miss quiet"}, {io_req, cpu_ready}, 0);
         @(negedge clk);
         chk(!io_req && !cpu_ready, {tag, " R1 miss quiet2"}, {io_req, cpu_ready}, 0);
         cpu_req = 1'b0;
         return;
      end
      if (!legal) begin
         chk(cpu_err && cpu_ready && !io_req, {tag, " R6 err"},
             {cpu_err, cpu_ready, io_req}, 32'b110);
         cpu_req = 1'b0;
         @(negedge clk);
         chk(!cpu_err && !cpu_ready && !io_req, {tag, " R6 err once"},
             {cpu_err, cpu_ready, io_req}, 0);
         return;
      end
      chk(io_req, {tag, " R8 io_req"}, 32'(io_req), 1);
      chk(io_addr == ea, {tag, mode ? " R3 addr" : " R2 addr"}, 32'(io_addr), 32'(ea));
      chk(io_size == sz && io_be == f_be(sz), {tag, " R7 size/be"},
          {io_size, io_be}, {sz, f_be(sz)});
      chk(io_we == we && io_wdata == wd, {tag, " R7 wdata"}, io_wdata, wd);
      for (int k = 0; k < dly; k++) begin
         if (k == 0 && cfg_mid >= 0) begin
            cfg_wr = 1'b1; cfg_port = 16'h0850; cfg_wdata = 8'(cfg_mid);
         end
         @(negedge clk);
         if (k == 0 && cfg_mid >= 0) begin
            cfg_wr = 1'b0;
            mode = cfg_mid[0];
         end
         chk(io_req && io_addr == ea && io_wdata == wd && !cpu_ready,
             {tag, " R8 R9 hold"}, 32'(io_addr), 32'(ea));
      end
      rd = $urandom;
      io_ready = 1'b1; io_rdata = rd;
      #1;
      chk(cpu_ready && !cpu_err && cpu_rdata == rd, {tag, " R7 R8 rdata"}, cpu_rdata, rd);
      @(negedge clk);
      io_ready = 1'b0; cpu_req = 1'b0;
      chk(!io_req && !cpu_ready, {tag, " R8 release"}, {io_req, cpu_ready}, 0);
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            summary();
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(!io_req && !cpu_ready && !cpu_err, "R5 R8 reset outputs",
          {io_req, cpu_ready, cpu_err}, 0);
      rst_n = 1'b1;
      // R5: out of reset in contiguous mode
      access(32'h8000_1234, 3'd4, 1'b1, 32'hA5A5_1234, 0, -1, -1, "R5 reset mode");
      access(32'h8012_1234, 3'd2, 1'b0, 32'h0, 2, -1, -1, "R4 cont high bits");
      access(32'h7FFF_FFFC, 3'd4, 1'b0, 32'h0, 0, -1, -1, "R1 below");
      access(32'h8080_0000, 3'd1, 1'b0, 32'h0, 0, -1, -1, "R1 above");
      access(32'h807F_FFFF, 3'd1, 1'b1, 32'h55, 1, -1, -1, "R1 last byte");
      // R5: wrong port and upper data bits have no effect
      cfg_write(16'h0851, 8'h01);
      mode = 1'b0;
      access(32'h8000_101F, 3'd1, 1'b0, 32'h0, 0, -1, -1, "R5 wrong port");
      cfg_write(16'h0850, 8'hFE);
      access(32'h8000_101F, 3'd1, 1'b0, 32'h0, 0, -1, -1, "R5 upper bits");
      cfg_write(16'h0850, 8'h01);
      access(32'h8000_101F, 3'd1, 1'b0, 32'h0, 0, -1, -1, "R3 sparse basic");
      access(32'h807F_F01F, 3'd2, 1'b1, 32'hBEEF, 1, -1, -1, "R3 sparse top");
      access(32'h8000_1FE3, 3'd1, 1'b0, 32'h0, 0, -1, -1, "R4 sparse skip a");
      access(32'h8000_1003, 3'd1, 1'b0, 32'h0, 0, -1, -1, "R4 sparse skip b");
      access(32'h8000_0003, 3'd4, 1'b1, 32'h0102_0304, 0, -1, -1, "R10 unaligned");
      access(32'h8000_3001, 3'd2, 1'b0, 32'h0, 0, -1, -1, "R10 unaligned half");
      access(32'h8000_0000, 3'd0, 1'b0, 32'h0, 0, -1, -1, "R6 size0");
      access(32'h8000_0000, 3'd3, 1'b1, 32'h0, 0, -1, -1, "R6 size3");
      access(32'h8000_0000, 3'd7, 1'b0, 32'h0, 0, -1, -1, "R6 size7");
      access(32'h8004_5678, 3'd4, 1'b0, 32'h0, 4, -1, 0, "R9 in flight");
      access(32'h8004_5678, 3'd4, 1'b0, 32'h0, 0, -1, -1, "R9 after change");
      access(32'h8004_5678, 3'd4, 1'b0, 32'h0, 1, 1, -1, "R9 same cycle");
      access(32'h8004_5678, 3'd4, 1'b0, 32'h0, 0, -1, -1, "R9 next uses new");
      for (int n = 0; n < 300; n++) begin
         logic [31:0] a;
         logic [2:0]  s;
         int          pick;
         pick = int'($urandom_range(0, 9));
         if (pick == 0) a = $urandom;
         else a = 32'h8000_0000 | ($urandom & 32'h007F_FFFF);
         pick = int'($urandom_range(0, 9));
         s = (pick < 3) ? 3'd1 : (pick < 6) ? 3'd2 : (pick < 9) ? 3'd4 : 3'($urandom);
         if ($urandom_range(0, 7) == 0) cfg_write(16'h0850, 8'($urandom));
         access(a, s, 1'($urandom), $urandom, int'($urandom_range(0, 3)),
                ($urandom_range(0, 15) == 0) ? int'($urandom_range(0, 1)) : -1,
                ($urandom_range(0, 15) == 0) ? int'($urandom_range(0, 1)) : -1,
                "random");
      end
      summary();
   end
endmodule